// File: doc/BRIEF.md
# First-Fit Page Allocator

This block hands out runs of contiguous pages from a fixed pool of 128 buffer pages. An occupancy bitmap is held internally as four 32-bit words, with one bit per page. A requester asks for a run of 1, 2, 4 or 8 pages. The block scans candidate start pages upward from page 0, one page per clock, and accepts the first start at which every page of the run is unoccupied. It marks those pages occupied and returns the start page. When no start fits, it returns an out-of-space result.

A release request names a start page and a size code. The matching pages are cleared only if the release is legitimate. A release is legitimate when every page it names is occupied, none lies in the reserved low region and the run stays inside the pool; otherwise the bitmap is left as it was and an error status is returned. The low pages are occupied from reset and are never handed out.

Requests use a valid/ready handshake. Each accepted request produces exactly one single-cycle response carrying a status and a page number. While a search runs, `busy` is high and `req_ready` is low, so further requests of either kind wait.

Top module: `pga_alloc`

## Requirements
- R1: After reset `req_ready` is 1, `busy` is 0 and `rsp_valid` is 0, and pages 0 to 3 are occupied and stay occupied for the whole run.
- R2: The size code `req_size` values 0, 1, 2 and 3 select runs of 1, 2, 4 and 8 pages.
- R3: An allocation returns the lowest start page whose whole run is free; candidate starts step by one page with no alignment to the run length.
- R4: A successful allocation marks every page of the returned run occupied, so later allocations skip them.
- R5: When no start page s with s + run length <= 128 has a free run, the response status is out-of-space (`rsp_status` = 1) and the bitmap is unchanged.
- R6: One candidate is examined per clock. When an allocation is accepted at edge k and ends at candidate s, the response is registered at edge k+1+s. A failing search ends at candidate 129 minus the run length.
- R7: From the accepting edge of an allocation until its response edge, `busy` is 1 and `req_ready` is 0; both return to idle values with the response.
- R8: A legitimate release (`req_op` = 1) clears exactly the pages of its run and responds with status OK (`rsp_status` = 0) at the accepting edge.
- R9: A release that touches a free page or a reserved page, or that runs past page 127, responds with status bad-release (`rsp_status` = 2) and leaves the bitmap unchanged.
- R10: A successful allocation responds with status OK and `rsp_page` equal to the run's start page; a release echoes its start page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_op | input | 1 | 0 = allocate, 1 = release |
| req_size | input | 2 | Run size code: run length is 2 to the power of the code |
| req_page | input | 7 | Start page of a release (ignored for allocate) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 OK, 1 out-of-space, 2 bad release |
| rsp_page | output | 8 | Start page of the run (allocate) or echoed start page (release) |
| busy | output | 1 | Allocation search in progress |

## Verification
The in-line assertions check several properties on every cycle: the reserved pages never lose their occupied mark, a set never lands on an occupied page, and a clear only ever removes pages that are fully occupied and outside the reserved region. They also check that the search candidate advances by exactly one per cycle and that every commit and every out-of-space result produces the matching response. Only the bench's scenarios can show which start page first-fit picks, and they confirm that unaligned placement fills holes. They also show the exact response latency for each start, that a rejected release really left the bitmap intact (seen through a later allocation), and how the pool behaves when nearly full.

// File: rtl/pga_pkg.sv
package pga_pkg;

   typedef enum logic [1:0] {
      ST_OK      = 2'd0,
      ST_NOSPACE = 2'd1,
      ST_BADFREE = 2'd2
   } pga_status_e;

   typedef enum logic {
      OP_ALLOC = 1'b0,
      OP_FREE  = 1'b1
   } pga_op_e;

   typedef enum logic {
      MASK_CMP   = 1'b0,
      MASK_SHIFT = 1'b1
   } pga_mask_style_e;

endpackage

// File: rtl/pga_run_mask.sv
module pga_run_mask
   import pga_pkg::*;
#(
   parameter int              NUM_PAGES  = 128,
   parameter int              SIZE_W     = 2,
   parameter pga_mask_style_e MASK_STYLE = MASK_CMP,
   localparam int             PAGE_W     = $clog2(NUM_PAGES)
) (
   input  logic [PAGE_W:0]      start,
   input  logic [SIZE_W-1:0]    size_code,
   output logic [NUM_PAGES-1:0] mask,
   output logic                 overrun
);

   localparam int POS_W = PAGE_W + 2;

   logic [POS_W-1:0] run_len;
   logic [POS_W-1:0] end_pos;

   assign run_len = POS_W'(1) << size_code;
   assign end_pos = {1'b0, start} + run_len;
   assign overrun = end_pos > POS_W'(NUM_PAGES);

   generate
      if (MASK_STYLE == MASK_CMP) begin : g_cmp
         for (genvar i = 0; i < NUM_PAGES; i++) begin : g_bit
            localparam logic [POS_W-1:0] IDX = POS_W'(i);
            assign mask[i] = (IDX >= {1'b0, start}) && (IDX < end_pos);
         end
      end else begin : g_shift
         logic [NUM_PAGES-1:0] base;
         assign base = ~({NUM_PAGES{1'b1}} << run_len);
         assign mask = base << start;
      end
   endgenerate

endmodule

// File: rtl/pga_bitmap.sv
module pga_bitmap #(
   parameter int NUM_PAGES  = 128,
   parameter int WORD_W     = 32,
   parameter int RESV_PAGES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_en,
   input  logic                 clr_en,
   input  logic [NUM_PAGES-1:0] mask,
   output logic                 hit_any,
   output logic                 hit_all,
   output logic                 resv_hit
);

   localparam int NUM_WORDS = NUM_PAGES / WORD_W;
   localparam logic [NUM_PAGES-1:0] RESV_MASK =
      {NUM_PAGES{1'b1}} >> (NUM_PAGES - RESV_PAGES);

   logic [NUM_PAGES-1:0] map;

   generate
      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
         localparam logic [WORD_W-1:0] RST_WORD = RESV_MASK[w*WORD_W +: WORD_W];
         logic [WORD_W-1:0] word_q;
         logic [WORD_W-1:0] word_msk;

         assign word_msk = mask[w*WORD_W +: WORD_W];

         always_ff @(posedge clk) begin
            if (!rst_n)
               word_q <= RST_WORD;
            else if (set_en)
               word_q <= word_q | word_msk;
            else if (clr_en)
               word_q <= word_q & ~word_msk;
         end

         assign map[w*WORD_W +: WORD_W] = word_q;
      end
   endgenerate

   assign hit_any  = |(map & mask);
   assign hit_all  = ((map & mask) == mask);
   assign resv_hit = |(mask & RESV_MASK);

   // R1
   resv_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (map & RESV_MASK) == RESV_MASK);

   // R4
   set_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |-> !hit_any);

   // R9
   clr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |-> hit_all && !resv_hit);

   // R8
   set_clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_en && clr_en));

endmodule

// File: rtl/pga_ctrl.sv
module pga_ctrl
   import pga_pkg::*;
#(
   parameter int  NUM_PAGES = 128,
   parameter int  SIZE_W    = 2,
   localparam int PAGE_W    = $clog2(NUM_PAGES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_op,
   input  logic [SIZE_W-1:0] req_size,
   input  logic [PAGE_W-1:0] req_page,
   output logic              req_ready,
   output logic              busy,
   input  logic              hit_any,
   input  logic              hit_all,
   input  logic              resv_hit,
   input  logic              overrun,
   output logic [PAGE_W:0]   mask_start,
   output logic [SIZE_W-1:0] mask_size,
   output logic              set_en,
   output logic              clr_en,
   output logic              rsp_valid,
   output logic [1:0]        rsp_status,
   output logic [PAGE_W:0]   rsp_page
);

   logic              searching_q;
   logic [PAGE_W:0]   cand_q;
   logic [SIZE_W-1:0] size_q;
   logic              accept;
   logic              free_ok;
   pga_status_e       status_q;

   assign req_ready  = !searching_q;
   assign busy       = searching_q;
   assign accept     = req_valid && !searching_q;

   assign mask_start = searching_q ? cand_q : {1'b0, req_page};
   assign mask_size  = searching_q ? size_q : req_size;

   assign free_ok = accept && (req_op == OP_FREE) && !overrun && !resv_hit && hit_all;
   assign set_en  = searching_q && !overrun && !hit_any;
   assign clr_en  = free_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         searching_q <= 1'b0;
         cand_q      <= '0;
         size_q      <= '0;
         rsp_valid   <= 1'b0;
         status_q    <= ST_OK;
         rsp_page    <= '0;
      end else begin
         rsp_valid <= 1'b0;
         if (searching_q) begin
            if (overrun) begin
               searching_q <= 1'b0;
               rsp_valid   <= 1'b1;
               status_q    <= ST_NOSPACE;
               rsp_page    <= cand_q;
            end else if (!hit_any) begin
               searching_q <= 1'b0;
               rsp_valid   <= 1'b1;
               status_q    <= ST_OK;
               rsp_page    <= cand_q;
            end else begin
               cand_q <= cand_q + 1'b1;
            end
         end else if (accept) begin
            if (req_op == OP_ALLOC) begin
               searching_q <= 1'b1;
               cand_q      <= '0;
               size_q      <= req_size;
            end else begin
               rsp_valid <= 1'b1;
               status_q  <= free_ok ? ST_OK : ST_BADFREE;
               rsp_page  <= {1'b0, req_page};
            end
         end
      end
   end

   assign rsp_status = status_q;

   // R6
   cand_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (searching_q && $past(searching_q)) |-> cand_q == $past(cand_q) + 1'b1);

   // R4
   set_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> rsp_valid && rsp_status == ST_OK && !busy);

   // R5
   nospace_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (searching_q && overrun) |=> rsp_valid && rsp_status == ST_NOSPACE);

   // R7
   idle_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_op == OP_ALLOC) |=> busy && !rsp_valid);

endmodule

// File: rtl/pga_alloc.sv
module pga_alloc
   import pga_pkg::*;
#(
   parameter int              NUM_PAGES  = 128,
   parameter int              WORD_W     = 32,
   parameter int              RESV_PAGES = 4,
   parameter int              SIZE_W     = 2,
   parameter pga_mask_style_e MASK_STYLE = MASK_CMP,
   localparam int             PAGE_W     = $clog2(NUM_PAGES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_op,
   input  logic [SIZE_W-1:0] req_size,
   input  logic [PAGE_W-1:0] req_page,
   output logic              rsp_valid,
   output logic [1:0]        rsp_status,
   output logic [PAGE_W:0]   rsp_page,
   output logic              busy
);

   localparam int MAX_RUN = 1 << ((1 << SIZE_W) - 1);

   generate
      if (NUM_PAGES != (1 << PAGE_W)) begin : g_bad_pages
         $error("pga_alloc: NUM_PAGES must be a power of two");
      end
      if ((NUM_PAGES % WORD_W) != 0) begin : g_bad_word
         $error("pga_alloc: NUM_PAGES must be a multiple of WORD_W");
      end
      if (RESV_PAGES < 0 || RESV_PAGES >= NUM_PAGES) begin : g_bad_resv
         $error("pga_alloc: RESV_PAGES out of range");
      end
      if (MAX_RUN > NUM_PAGES) begin : g_bad_size
         $error("pga_alloc: largest run exceeds the pool");
      end
   endgenerate

   logic [NUM_PAGES-1:0] mask;
   logic [PAGE_W:0]      mask_start;
   logic [SIZE_W-1:0]    mask_size;
   logic                 overrun;
   logic                 hit_any;
   logic                 hit_all;
   logic                 resv_hit;
   logic                 set_en;
   logic                 clr_en;

   pga_run_mask #(
      .NUM_PAGES  (NUM_PAGES),
      .SIZE_W     (SIZE_W),
      .MASK_STYLE (MASK_STYLE)
   ) u_mask (
      .start     (mask_start),
      .size_code (mask_size),
      .mask      (mask),
      .overrun   (overrun)
   );

   pga_bitmap #(
      .NUM_PAGES  (NUM_PAGES),
      .WORD_W     (WORD_W),
      .RESV_PAGES (RESV_PAGES)
   ) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (set_en),
      .clr_en   (clr_en),
      .mask     (mask),
      .hit_any  (hit_any),
      .hit_all  (hit_all),
      .resv_hit (resv_hit)
   );

   pga_ctrl #(
      .NUM_PAGES (NUM_PAGES),
      .SIZE_W    (SIZE_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_op     (req_op),
      .req_size   (req_size),
      .req_page   (req_page),
      .req_ready  (req_ready),
      .busy       (busy),
      .hit_any    (hit_any),
      .hit_all    (hit_all),
      .resv_hit   (resv_hit),
      .overrun    (overrun),
      .mask_start (mask_start),
      .mask_size  (mask_size),
      .set_en     (set_en),
      .clr_en     (clr_en),
      .rsp_valid  (rsp_valid),
      .rsp_status (rsp_status),
      .rsp_page   (rsp_page)
   );

   // R10
   ok_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == ST_OK) |-> rsp_page < (PAGE_W+1)'(NUM_PAGES));

endmodule

// File: tb/sim_pga_alloc.sv
`timescale 1ns/1ps
module sim_pga_alloc;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic       req_op = 1'b0;
   logic [1:0] req_size = 2'd0;
   logic [6:0] req_page = 7'd0;
   logic       rsp_valid;
   logic [1:0] rsp_status;
   logic [7:0] rsp_page;
   logic       busy;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   localparam logic [1:0] S_OK = 2'd0, S_NOSP = 2'd1, S_BAD = 2'd2;

   always #2.5 clk = ~clk;

   pga_alloc u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_size(req_size), .req_page(req_page),
      .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_page(rsp_page),
      .busy(busy)
   );

   task automatic chk(input bit ok, input string rq, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   // one request, with latency counted in negedges after the accepting edge
   task automatic run_req(input logic op, input logic [1:0] sz, input logic [6:0] pg,
                          input logic [1:0] exp_st, input int exp_pg, input int exp_lat,
                          input string rq);
      int lat = 0;
      bit busy_ok = 1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R7", "ready before request", int'(req_ready), 1);
      req_valid = 1'b1; req_op = op; req_size = sz; req_page = pg;
      @(posedge clk);
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
         lat++;
         if (rsp_valid) break;
         if (!(busy && !req_ready)) busy_ok = 0;
      end
      chk(busy_ok, "R7", "busy high and ready low during search", int'(busy_ok), 1);
      chk(rsp_valid == 1'b1, rq, "response seen", int'(rsp_valid), 1);
      chk(rsp_status == exp_st, rq, "status", int'(rsp_status), int'(exp_st));
      if (exp_pg >= 0)
         chk(int'(rsp_page) == exp_pg, rq, "page", int'(rsp_page), exp_pg);
      chk(lat == exp_lat, "R6", "latency", lat, exp_lat);
      chk(!busy && req_ready, "R7", "idle after response", int'(busy), 0);
   endtask

   task automatic t_reset();
      chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
      chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
      chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
   endtask

   task automatic t_first_fit();
      run_req(1'b0, 2'd0, 7'd0, S_OK, 4, 6, "R1");
      run_req(1'b0, 2'd1, 7'd0, S_OK, 5, 7, "R3");
      run_req(1'b0, 2'd2, 7'd0, S_OK, 7, 9, "R2");
      run_req(1'b0, 2'd3, 7'd0, S_OK, 11, 13, "R2");
   endtask

   task automatic t_release();
      run_req(1'b1, 2'd1, 7'd5, S_OK, 5, 1, "R8");
      run_req(1'b0, 2'd0, 7'd0, S_OK, 5, 7, "R8");
      run_req(1'b0, 2'd0, 7'd0, S_OK, 6, 8, "R4");
      run_req(1'b0, 2'd1, 7'd0, S_OK, 19, 21, "R4");
   endtask

   task automatic t_bad_release();
      run_req(1'b1, 2'd0, 7'd2,   S_BAD, 2, 1, "R9");
      run_req(1'b1, 2'd0, 7'd40,  S_BAD, 40, 1, "R9");
      run_req(1'b1, 2'd1, 7'd3,   S_BAD, 3, 1, "R9");
      run_req(1'b1, 2'd1, 7'd20,  S_BAD, 20, 1, "R9");
      run_req(1'b1, 2'd1, 7'd127, S_BAD, 127, 1, "R9");
      // page 20 must still be occupied, so first fit lands on 21
      run_req(1'b0, 2'd0, 7'd0, S_OK, 21, 23, "R9");
   endtask

   task automatic t_fill();
      for (int k = 0; k < 13; k++)
         run_req(1'b0, 2'd3, 7'd0, S_OK, 22 + 8*k, 24 + 8*k, "R10");
      run_req(1'b0, 2'd3, 7'd0, S_NOSP, -1, 123, "R5");
      run_req(1'b0, 2'd1, 7'd0, S_OK, 126, 128, "R3");
      run_req(1'b0, 2'd0, 7'd0, S_NOSP, -1, 130, "R5");
   endtask

   task automatic t_hole();
      run_req(1'b1, 2'd3, 7'd30, S_OK, 30, 1, "R8");
      run_req(1'b0, 2'd2, 7'd0, S_OK, 30, 32, "R3");
      run_req(1'b0, 2'd1, 7'd0, S_OK, 34, 36, "R3");
      run_req(1'b0, 2'd2, 7'd0, S_NOSP, -1, 127, "R5");
      run_req(1'b0, 2'd0, 7'd0, S_OK, 36, 38, "R5");
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_first_fit();
      t_release();
      t_bad_release();
      t_fill();
      t_hole();
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule